// File: doc/BRIEF.md
# Slot-Configurable 4-Bit Accumulator Processor

This block is a very small stored-program processor. It holds a 4-bit accumulator, a program store and a 4-bit data register file, both filled through a load port while the machine is not running. Each instruction word carries a 2-bit opcode in its top bits and a data address in its low bits. The opcode selects one of four slots. A parameter binds each slot to one operation from a fixed menu: add, store, shift right, shift left, skip when the accumulator is nonzero, punch, and no-op. A slot that is bound to nothing acts as the halt instruction, so halt has no encoding of its own and may sit in any slot.

A run pulse starts execution at address 0 with a cleared accumulator. Each instruction takes one clock. The punch operation sends the accumulator value out on a valid/ready stream. While a punched value is still waiting, a further punch stalls the machine until the consumer accepts. The other instructions never wait. Executing an empty slot stops the machine for good: only reset brings it back.

Top module: `slotcpu4`

## Requirements
- R1: The accumulator is 4 bits wide. Add sums it with the addressed data word and drops the carry (result modulo 16).
- R2: The instruction word is {opcode[5:4], address[3:0]}. The operation an opcode runs is the one the slot parameter gives it, and an operation behaves the same whichever slot holds it.
- R3: Executing an opcode whose slot is empty sets `halted` and clears `busy`. `halted` then stays set and the accumulator holds its value until reset, and a run pulse is ignored.
- R4: Skip jumps over the next instruction (program counter +2) when the accumulator is nonzero. Otherwise it advances by 1.
- R5: Shift right and shift left move the accumulator by one bit and fill with zero. The bit shifted out is lost.
- R6: Store writes the accumulator to the addressed data word and leaves the accumulator unchanged.
- R7: Punch places the accumulator on `out_data` with `out_valid`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold, and a further punch stalls with the program counter frozen. A punch in the same cycle as a completed transfer replaces the data without a gap.
- R8: A run pulse when the machine is not halted clears the accumulator and sets the program counter to 0 in the following cycle, and `busy` rises. This also happens while the machine is running (restart).
- R9: Load writes are accepted only while `busy` is low. A load while running has no effect on program or data.
- R10: After reset, `busy`, `halted` and `out_valid` are low and the accumulator is 0.
- R11: Every executed instruction takes exactly one clock. The program counter wraps from the last address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Start / restart pulse |
| ld_en | input | 1 | Load write enable (ignored while busy) |
| ld_to_data | input | 1 | 1: load targets data file, 0: program store |
| ld_addr | input | 4 | Load address |
| ld_word | input | 6 | Load value (data loads use the low 4 bits) |
| out_valid | output | 1 | Punched value available |
| out_ready | input | 1 | Consumer accepts the punched value |
| out_data | output | 4 | Punched accumulator value |
| acc_q | output | 4 | Current accumulator |
| busy | output | 1 | Machine is executing |
| halted | output | 1 | Machine has stopped on an empty slot |

## Verification
The assertions assume a consumer that may hold `out_ready` low for any number of cycles. They also assume that `run` is a short pulse whose effect is judged only after the following edge. The stimulus loads memories only while the machine is idle, except in one directed case that checks such loads are ignored. Random runs keep `out_ready` high so that the cycle-counted reference model needs no stall accounting. Back-pressure is exercised only in a directed sequence whose stall cycles are known exactly.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int OPC_W     = $clog2(NUM_SLOTS);

  typedef enum logic [2:0] {
    OP_EMPTY, OP_ADD, OP_STORE, OP_SHR, OP_SHL, OP_SKIP, OP_PUNCH, OP_NOP
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RUN, ST_HALT
  } seq_st_e;
endpackage

// File: rtl/acc4_regfile.sv
module acc4_regfile #(
  parameter int WIDTH = 4,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc4_slot_decode.sv
module acc4_slot_decode
  import acc4_pkg::*;
#(
  parameter op_e SLOT_MAP [NUM_SLOTS] = '{OP_ADD, OP_SKIP, OP_PUNCH, OP_EMPTY}
) (
  input  logic [OPC_W-1:0] opc,
  output op_e              op
);
  op_e lut [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign lut[g] = SLOT_MAP[g];
  end

  assign op = lut[opc];
endmodule

// File: rtl/acc4_alu.sv
module acc4_alu
  import acc4_pkg::*;
#(
  parameter int W = 4
) (
  input  op_e          op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc_next
);
  always_comb begin
    unique case (op)
      OP_ADD:  acc_next = acc + operand;
      OP_SHR:  acc_next = acc >> 1;
      OP_SHL:  acc_next = acc << 1;
      default: acc_next = acc;
    endcase
  end
endmodule

// File: rtl/acc4_seq.sv
module acc4_seq
  import acc4_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  op_e           op,
  input  logic          acc_nz,
  input  logic          stall,
  output logic [AW-1:0] pc,
  output logic          busy,
  output logic          halted,
  output logic          exec
);
  seq_st_e       st;
  logic [AW-1:0] step;

  assign step   = (op == OP_SKIP && acc_nz) ? AW'(2) : AW'(1);
  assign busy   = (st == ST_RUN);
  assign halted = (st == ST_HALT);
  assign exec   = busy && !run && (op != OP_EMPTY) && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pc <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (run) begin
          st <= ST_RUN;
          pc <= '0;
        end
        ST_RUN: begin
          if (run)                 pc <= '0;
          else if (op == OP_EMPTY) st <= ST_HALT;
          else if (!stall)         pc <= pc + step;
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/slotcpu4.sv
module slotcpu4
  import acc4_pkg::*;
#(
  parameter int  WORD_W = 4,
  parameter int  ADDR_W = 4,
  parameter op_e SLOT_MAP [NUM_SLOTS] = '{OP_ADD, OP_SKIP, OP_PUNCH, OP_EMPTY}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      ld_en,
  input  logic                      ld_to_data,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [OPC_W+ADDR_W-1:0]   ld_word,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORD_W-1:0]         out_data,
  output logic [WORD_W-1:0]         acc_q,
  output logic                      busy,
  output logic                      halted
);
  localparam int INSTR_W = OPC_W + ADDR_W;

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] instr;
  logic [OPC_W-1:0]   opc;
  logic [ADDR_W-1:0]  opaddr;
  logic [WORD_W-1:0]  operand;
  logic [WORD_W-1:0]  acc_next;
  op_e                op;
  logic               stall;
  logic               exec;
  logic               prog_we;
  logic               data_we;
  logic               store_fire;
  logic               punch_fire;
  logic [ADDR_W-1:0]  data_waddr;
  logic [WORD_W-1:0]  data_wdata;

  assign opc    = instr[INSTR_W-1 -: OPC_W];
  assign opaddr = instr[ADDR_W-1:0];

  assign stall      = (op == OP_PUNCH) && out_valid && !out_ready;
  assign store_fire = exec && (op == OP_STORE);
  assign punch_fire = exec && (op == OP_PUNCH);

  assign prog_we    = ld_en && !ld_to_data && !busy;
  assign data_we    = store_fire || (ld_en && ld_to_data && !busy);
  assign data_waddr = store_fire ? opaddr : ld_addr;
  assign data_wdata = store_fire ? acc_q  : ld_word[WORD_W-1:0];

  acc4_regfile #(.WIDTH(INSTR_W), .AW(ADDR_W)) u_prog (
    .clk   (clk),
    .we    (prog_we),
    .waddr (ld_addr),
    .wdata (ld_word),
    .raddr (pc),
    .rdata (instr)
  );

  acc4_regfile #(.WIDTH(WORD_W), .AW(ADDR_W)) u_data (
    .clk   (clk),
    .we    (data_we),
    .waddr (data_waddr),
    .wdata (data_wdata),
    .raddr (opaddr),
    .rdata (operand)
  );

  acc4_slot_decode #(.SLOT_MAP(SLOT_MAP)) u_dec (
    .opc (opc),
    .op  (op)
  );

  acc4_alu #(.W(WORD_W)) u_alu (
    .op       (op),
    .acc      (acc_q),
    .operand  (operand),
    .acc_next (acc_next)
  );

  acc4_seq #(.AW(ADDR_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .op     (op),
    .acc_nz (acc_q != '0),
    .stall  (stall),
    .pc     (pc),
    .busy   (busy),
    .halted (halted),
    .exec   (exec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              acc_q <= '0;
    else if (run && !halted) acc_q <= '0;
    else if (exec)           acc_q <= acc_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (punch_fire) begin
      out_valid <= 1'b1;
      out_data  <= acc_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/slotcpu4_chk.sv
module slotcpu4_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [WORD_W-1:0] acc_q,
  input logic              busy,
  input logic              halted
);
  p_halt_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !busy);

  p_halt_acc_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(acc_q));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_run_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halted) |=> (acc_q == '0 && busy));
endmodule

bind slotcpu4 slotcpu4_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .acc_q     (acc_q),
  .busy      (busy),
  .halted    (halted)
);

// File: tb/slotcpu4_test.sv
module slotcpu4_test;
  import acc4_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;

  localparam op_e MAP_A [4] = '{OP_ADD, OP_SKIP, OP_PUNCH, OP_EMPTY};
  localparam op_e MAP_B [4] = '{OP_EMPTY, OP_ADD, OP_STORE, OP_SHR};
  localparam op_e MAP_C [4] = '{OP_SHL, OP_NOP, OP_ADD, OP_EMPTY};

  logic       clk = 0;
  logic       rst_n = 0;
  logic       run [NI];
  logic       ld_en [NI];
  logic       ld_to_data = 0;
  logic [3:0] ld_addr = 0;
  logic [5:0] ld_word = 0;
  logic       out_ready = 1;
  logic       ov [NI];
  logic [3:0] od [NI];
  logic [3:0] accv [NI];
  logic       bsy [NI];
  logic       hlt [NI];

  int checks = 0;
  int fails  = 0;
  logic mon_clr = 1;
  int pcnt = 0;
  int psig = 0;

  logic [5:0] mprog [NI][16];
  logic [3:0] mdata [NI][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  slotcpu4 uut (
    .clk(clk), .rst_n(rst_n), .run(run[0]), .ld_en(ld_en[0]), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_word(ld_word), .out_valid(ov[0]), .out_ready(out_ready),
    .out_data(od[0]), .acc_q(accv[0]), .busy(bsy[0]), .halted(hlt[0]));

  slotcpu4 #(.SLOT_MAP(MAP_B)) uut_b (
    .clk(clk), .rst_n(rst_n), .run(run[1]), .ld_en(ld_en[1]), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_word(ld_word), .out_valid(ov[1]), .out_ready(out_ready),
    .out_data(od[1]), .acc_q(accv[1]), .busy(bsy[1]), .halted(hlt[1]));

  slotcpu4 #(.SLOT_MAP(MAP_C)) uut_c (
    .clk(clk), .rst_n(rst_n), .run(run[2]), .ld_en(ld_en[2]), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_word(ld_word), .out_valid(ov[2]), .out_ready(out_ready),
    .out_data(od[2]), .acc_q(accv[2]), .busy(bsy[2]), .halted(hlt[2]));

  // punch monitor on the first instance: counts completed transfers
  always @(posedge clk) begin
    if (mon_clr) begin
      pcnt = 0;
      psig = 0;
    end else if (ov[0] && out_ready) begin
      pcnt = pcnt + 1;
      psig = psig * 7 + int'(od[0]);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hung, expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end

  function automatic [5:0] ins(input int opc, input int a);
    ins = {opc[1:0], a[3:0]};
  endfunction

  function automatic op_e map_of(input int inst, input int opc);
    case (inst)
      0:       map_of = MAP_A[opc];
      1:       map_of = MAP_B[opc];
      default: map_of = MAP_C[opc];
    endcase
  endfunction

  // reference model: n one-cycle steps from a run pulse, ready held high
  task automatic model(input int inst, input int n, output logic [3:0] a,
                       output logic h, output int pc_n, output int sig);
    logic [3:0] d [16];
    int pc;
    logic [5:0] w;
    op_e op;
    pc = 0; a = 0; h = 0; pc_n = 0; sig = 0;
    for (int i = 0; i < 16; i++) d[i] = mdata[inst][i];
    for (int s = 1; s <= n && !h; s++) begin
      w  = mprog[inst][pc];
      op = map_of(inst, int'(w[5:4]));
      case (op)
        OP_EMPTY: h = 1;
        OP_ADD:   a = a + d[w[3:0]];
        OP_STORE: d[w[3:0]] = a;
        OP_SHR:   a = a >> 1;
        OP_SHL:   a = a << 1;
        OP_SKIP:  if (a != 0) pc = (pc + 1) % 16;
        OP_PUNCH: if (s < n) begin pc_n++; sig = sig * 7 + int'(a); end
        default: ;
      endcase
      if (!h) pc = (pc + 1) % 16;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mon_clr = 1;
    for (int i = 0; i < NI; i++) begin run[i] = 0; ld_en[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1; mon_clr = 0;
  endtask

  task automatic ld(input int inst, input logic td, input int a, input logic [5:0] w);
    @(negedge clk);
    ld_en[inst] = 1; ld_to_data = td; ld_addr = a[3:0]; ld_word = w;
    if (td) mdata[inst][a] = w[3:0];
    else    mprog[inst][a] = w;
    @(posedge clk);
    #1 ld_en[inst] = 0;
  endtask

  task automatic start(input int inst);
    @(negedge clk);
    run[inst] = 1;
    @(negedge clk);
    run[inst] = 0;
  endtask

  logic [3:0] e_acc;
  logic       e_h;
  int         e_pc, e_sig;

  initial begin
    for (int i = 0; i < NI; i++) begin run[i] = 0; ld_en[i] = 0; end
    void'($urandom(32'd2024));
    do_reset();

    // R10: reset state
    for (int i = 0; i < NI; i++) begin
      check("R10 busy", bsy[i], 0);
      check("R10 halted", hlt[i], 0);
      check("R10 out_valid", ov[i], 0);
      check("R10 acc", accv[i], 0);
    end

    // R1 wrap, R3 halt on empty slot 3
    ld(0, 1, 0, 6'd9); ld(0, 1, 1, 6'd12);
    ld(0, 0, 0, ins(0, 0)); ld(0, 0, 1, ins(0, 1)); ld(0, 0, 2, ins(3, 0));
    start(0);
    repeat (3) @(negedge clk);
    check("R1 add wraps 9+12", accv[0], 5);
    check("R3 halted set", hlt[0], 1);
    check("R3 busy low", bsy[0], 0);
    start(0);
    repeat (2) @(negedge clk);
    check("R3 run ignored halted", hlt[0], 1);
    check("R3 acc frozen", accv[0], 5);

    // R4 skip not taken with zero accumulator
    do_reset();
    ld(0, 1, 0, 6'd2);
    ld(0, 0, 0, ins(1, 0)); ld(0, 0, 1, ins(0, 0)); ld(0, 0, 2, ins(2, 0)); ld(0, 0, 3, ins(3, 0));
    start(0);
    repeat (4) @(negedge clk);
    check("R4 zero acc no skip acc", accv[0], 2);
    check("R4 zero acc no skip halted", hlt[0], 1);
    check("R7 punch count", pcnt, 1);
    check("R7 punch value", psig, 2);

    // R4 skip taken with nonzero accumulator
    do_reset();
    ld(0, 0, 0, ins(0, 0)); ld(0, 0, 1, ins(1, 0)); ld(0, 0, 2, ins(0, 0));
    ld(0, 0, 3, ins(2, 0)); ld(0, 0, 4, ins(3, 0));
    start(0);
    repeat (3) @(negedge clk);
    check("R4 not halted after 3", hlt[0], 0);
    @(negedge clk);
    check("R4 skip taken acc", accv[0], 2);
    check("R4 skip taken halted at step 4", hlt[0], 1);

    // R5 R6 R2 on second map: ADD in slot1, SHR slot3, STORE slot2, empty slot0
    do_reset();
    ld(1, 1, 0, 6'hB); ld(1, 1, 3, 6'h0);
    ld(1, 0, 0, ins(1, 0)); ld(1, 0, 1, ins(3, 0)); ld(1, 0, 2, ins(2, 3));
    ld(1, 0, 3, ins(1, 3)); ld(1, 0, 4, ins(0, 0));
    start(1);
    repeat (2) @(negedge clk);
    check("R5 shift right 0xB", accv[1], 5);
    @(negedge clk);
    check("R6 store keeps acc", accv[1], 5);
    repeat (2) @(negedge clk);
    check("R6 stored value read back", accv[1], 10);
    check("R2 empty slot0 halts", hlt[1], 1);

    // R5 R2 on third map: SHL slot0, NOP slot1, ADD slot2, empty slot3
    ld(2, 1, 0, 6'hB);
    ld(2, 0, 0, ins(2, 0)); ld(2, 0, 1, ins(0, 0)); ld(2, 0, 2, ins(0, 0));
    ld(2, 0, 3, ins(1, 0)); ld(2, 0, 4, ins(3, 0));
    start(2);
    repeat (2) @(negedge clk);
    check("R5 shift left drops msb", accv[2], 6);
    repeat (3) @(negedge clk);
    check("R2 add in slot2 then shifts", accv[2], 12);
    check("R2 halted", hlt[2], 1);

    // R7 back-pressure
    do_reset();
    out_ready = 0;
    ld(0, 1, 0, 6'd5);
    ld(0, 0, 0, ins(0, 0)); ld(0, 0, 1, ins(2, 0)); ld(0, 0, 2, ins(0, 0));
    ld(0, 0, 3, ins(2, 0)); ld(0, 0, 4, ins(3, 0));
    start(0);
    repeat (6) @(negedge clk);
    check("R7 valid held", ov[0], 1);
    check("R7 data held", od[0], 5);
    check("R7 stalled not halted", hlt[0], 0);
    check("R7 acc during stall", accv[0], 10);
    out_ready = 1;
    @(negedge clk);
    check("R7 back-to-back data", od[0], 10);
    check("R7 back-to-back valid", ov[0], 1);
    @(negedge clk);
    check("R7 valid drops", ov[0], 0);
    check("R7 halted after", hlt[0], 1);
    check("R7 two transfers", pcnt, 2);

    // R8 restart, R9 load ignored while busy
    do_reset();
    ld(0, 1, 0, 6'd1);
    for (int i = 0; i < 16; i++) ld(0, 0, i, ins(0, 0));
    start(0);
    repeat (5) @(negedge clk);
    check("R11 one step per clock", accv[0], 5);
    ld_en[0] = 1; ld_to_data = 1; ld_addr = 0; ld_word = 6'd7;
    @(negedge clk);
    ld_en[0] = 0;
    check("R9 add after busy load", accv[0], 6);
    run[0] = 1;
    @(negedge clk);
    run[0] = 0;
    check("R8 restart clears acc", accv[0], 0);
    check("R8 busy", bsy[0], 1);
    repeat (3) @(negedge clk);
    check("R9 data unchanged by busy load", accv[0], 3);

    // R11 wrap
    do_reset();
    ld(0, 1, 0, 6'd1); ld(0, 1, 2, 6'd0);
    ld(0, 0, 0, ins(0, 0)); ld(0, 0, 1, ins(2, 0));
    for (int i = 2; i < 16; i++) ld(0, 0, i, ins(0, 2));
    start(0);
    repeat (17) @(negedge clk);
    check("R11 wrap add", accv[0], 2);
    check("R11 no punch yet", ov[0], 0);
    @(negedge clk);
    check("R11 second punch valid", ov[0], 1);
    check("R11 second punch data", od[0], 2);
    check("R11 first transfer count", pcnt, 1);

    // random programs against the reference model (R1-R6, R11)
    for (int inst = 0; inst < NI; inst++) begin
      for (int t = 0; t < 25; t++) begin
        do_reset();
        for (int i = 0; i < 16; i++) ld(inst, 0, i, 6'($urandom));
        for (int i = 0; i < 16; i++) ld(inst, 1, i, 6'($urandom));
        model(inst, 30, e_acc, e_h, e_pc, e_sig);
        start(inst);
        repeat (30) @(negedge clk);
        check("R1 random acc", accv[inst], e_acc);
        check("R3 random halted", hlt[inst], e_h);
        if (inst == 0) begin
          check("R7 random punch count", pcnt, e_pc);
          check("R7 random punch values", psig, e_sig);
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule